// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when the device is in reset and how it leaves reset. Five requesters can put it there: a power-on detector, a supply-drop detector, an oscillator-failure detector, an external active-low reset pin, and a software command. While it holds reset it tells the rest of the chip to reset its registers and buffer pointers and to float its digital pads. For hardware-caused resets it also stops the oscillator and pulls the reset pin low through an open-drain pulldown. The contents of the packet buffer are untouched. Only the pointers are told to go back to their defaults.

On release, the block restarts the oscillator and counts out a settle window. It then raises an oscillator-ready interrupt flag, counts out a self-initialization window, and raises a second flag to mark that initialization is done. A software reset keeps the oscillator running and leaves the pin alone. It goes straight from the hold window to self-initialization. A latched one-hot cause register records which source started the most recent reset. The host clears the interrupt flags with write-one-to-clear strobes and can mask them with a small enable register. All inputs are plain level or strobe controls. No data stream passes through the block, so it has no valid/ready port.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_req` is high, `in_reset`=1, `rst_pin_pd`=1, `osc_en`=0, `irq_flags`=00, `irq`=0 and `rst_cause`=5'b00001.
- R2: Whenever `in_reset` is 1, `reg_rst`, `bufptr_rst` and `pad_hiz` are 1. From the second reset cycle on, `irq_flags` is 00. Both interrupt enables are forced back to 1.
- R3: While in reset from any source other than software, `osc_en`=0 and `rst_pin_pd`=1.
- R4: A software reset (`sw_rst_cmd` high for one cycle) keeps `osc_en`=1 and `rst_pin_pd`=0. It skips the settle window and never raises the oscillator flag (`irq_flags[0]`). `irq_flags[1]` rises exactly INIT_CYC cycles after `in_reset` falls.
- R5: Reset is held until HOLD_CYC cycles have passed with no active request. Power-on, supply-drop and oscillator-fail requests pass a two-flop synchronizer, so `in_reset` falls on the (HOLD_CYC+2)-th rising edge after such a request is removed. For a software strobe it falls on the (HOLD_CYC+1)-th edge, counting the edge that samples the strobe.
- R6: After a hardware reset, `irq_flags[0]` rises exactly SETTLE_CYC cycles after `in_reset` falls.
- R7: `irq_flags[1]` rises exactly INIT_CYC cycles after `irq_flags[0]` rises.
- R8: `rst_cause` is one-hot: bit0 power-on, bit1 supply-drop, bit2 oscillator-fail, bit3 pin, bit4 software. When several requests are active together, the lowest bit wins. A higher-priority request arriving during a hold replaces the cause, and a hardware cause then switches on the pin pulldown and stops the oscillator.
- R9: A pin reset lasts exactly HOLD_CYC cycles once detected, provided the external driver releases the pin within that time. The block's own pulldown does not retrigger a reset after it lets go of the pin.
- R10: Writing 1 to bit n of `irq_clr` clears `irq_flags[n]` (bit0 oscillator-ready, bit1 init-done) on the next edge. Other flags are unchanged.
- R11: `irq` is the OR of the flags whose enable is 1. `ien_we` loads `ien_wdata` into the enables (bit0 oscillator-ready, bit1 init-done) outside reset.
- R12: Any new request during the settle or self-initialization window sends the block back to reset, and the pending flags are not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| pfail_req | input | 1 | Supply-drop request, active high, asynchronous |
| oscfail_req | input | 1 | Oscillator-failure request, active high, asynchronous |
| rst_pin_in | input | 1 | Level seen on the reset pin, low = reset |
| sw_rst_cmd | input | 1 | Software reset strobe, synchronous |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 2 | New interrupt enables |
| irq_clr | input | 2 | Write-one-to-clear strobes for the flags |
| in_reset | output | 1 | Device is held in reset |
| reg_rst | output | 1 | Register reset request (level) |
| bufptr_rst | output | 1 | Buffer pointer reset request |
| pad_hiz | output | 1 | Digital pads to high impedance with pull-up |
| osc_en | output | 1 | Oscillator enable |
| rst_pin_pd | output | 1 | Open-drain pulldown on the reset pin |
| irq | output | 1 | Interrupt output |
| irq_flags | output | 2 | Oscillator-ready (bit0) and init-done (bit1) flags |
| rst_cause | output | 5 | One-hot cause of the latest reset |

## Verification
The hardest case to reach is the pin reset that the block itself is keeping low. The block's own pulldown still holds the pin down, and the delayed copies in the synchronizer still report a low level for a few cycles after release. A wrong mask would restart the reset at exactly that moment. The stimulus pulls the pin low for a random number of cycles and releases it before the hold ends. It then checks the exact fall time and watches that `in_reset` stays low through the whole settle and init windows. A sequence with a software strobe followed by a supply drop during the hold, and a second with an oscillator failure during the settle window, reach the cause-upgrade and restart paths.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NUM_SRC   = 5;
  localparam int SRC_POR   = 0;
  localparam int SRC_PFAIL = 1;
  localparam int SRC_OSCF  = 2;
  localparam int SRC_PIN   = 3;
  localparam int SRC_SW    = 4;
  localparam int NUM_IRQ   = 2;
  localparam int IRQ_OSC   = 0;
  localparam int IRQ_INIT  = 1;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_INIT   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic               clk,
  input  logic               arst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               in_hold,
  output logic [NUM_SRC-1:0] cause
);
  localparam int IW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] cause_q;
  logic [IW-1:0]      pick_idx;
  logic [IW-1:0]      cur_idx;
  logic               load;

  always_comb begin
    pick_idx = IW'(NUM_SRC - 1);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) pick_idx = IW'(i);
    end
  end

  always_comb begin
    cur_idx = IW'(NUM_SRC - 1);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cause_q[i]) cur_idx = IW'(i);
    end
  end

  assign load = (|req) && (!in_hold || (pick_idx < cur_idx));

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      cause_q <= NUM_SRC'(1) << SRC_POR;
    else if (load) cause_q <= NUM_SRC'(1) << pick_idx;
  end

  assign cause = cause_q;
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int SETTLE_CYC = 4000,
  parameter int INIT_CYC   = 2000
) (
  input  logic       clk,
  input  logic       arst,
  input  logic       req_any,
  input  logic       skip_settle,
  output seq_state_e state,
  output logic       osc_done,
  output logic       init_done
);
  localparam int MAX_AB = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int MAXC   = (MAX_AB > INIT_CYC) ? MAX_AB : INIT_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  seq_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic hold_last, settle_last, init_last;

  assign hold_last   = (cnt_q == CW'(HOLD_CYC - 1));
  assign settle_last = (cnt_q == CW'(SETTLE_CYC - 1));
  assign init_last   = (cnt_q == CW'(INIT_CYC - 1));

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else if (req_any) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_HOLD: begin
          if (hold_last) begin
            st_q  <= skip_settle ? ST_INIT : ST_SETTLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_last) begin
            st_q  <= ST_INIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_INIT: begin
          if (init_last) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign state     = st_q;
  assign osc_done  = !req_any && (st_q == ST_SETTLE) && settle_last;
  assign init_done = !req_any && (st_q == ST_INIT) && init_last;
endmodule

// File: rtl/rstseq_irq.sv
module rstseq_irq
  import rstseq_pkg::*;
(
  input  logic               clk,
  input  logic               arst,
  input  logic               in_hold,
  input  logic [NUM_IRQ-1:0] set,
  input  logic [NUM_IRQ-1:0] clr,
  input  logic               ien_we,
  input  logic [NUM_IRQ-1:0] ien_wdata,
  output logic [NUM_IRQ-1:0] flags,
  output logic               irq
);
  logic [NUM_IRQ-1:0] flag_q;
  logic [NUM_IRQ-1:0] ien_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      flag_q <= '0;
      ien_q  <= '1;
    end else if (in_hold) begin
      flag_q <= '0;
      ien_q  <= '1;
    end else begin
      flag_q <= (flag_q & ~clr) | set;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ien_q);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYC   = 16,
  parameter int SETTLE_CYC = 4000,
  parameter int INIT_CYC   = 2000,
  parameter int SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               pfail_req,
  input  logic               oscfail_req,
  input  logic               rst_pin_in,
  input  logic               sw_rst_cmd,
  input  logic               ien_we,
  input  logic [NUM_IRQ-1:0] ien_wdata,
  input  logic [NUM_IRQ-1:0] irq_clr,
  output logic               in_reset,
  output logic               reg_rst,
  output logic               bufptr_rst,
  output logic               pad_hiz,
  output logic               osc_en,
  output logic               rst_pin_pd,
  output logic               irq,
  output logic [NUM_IRQ-1:0] irq_flags,
  output logic [NUM_SRC-1:0] rst_cause
);
  localparam int MASK_LEN = SYNC_STG + 1;

  logic               por_s;
  logic [2:0]         async_s;
  logic [MASK_LEN-1:0] pd_hist;
  logic               pin_req;
  logic [NUM_SRC-1:0] req;
  logic               in_hold;
  logic               hw_kind;
  logic               pd_w;
  logic               osc_done, init_done;
  seq_state_e         state;
  logic [NUM_SRC-1:0] cause;

  rstseq_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_por_sync (
    .clk(clk), .arst(por_req), .d(1'b0), .q(por_s)
  );

  rstseq_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_req_sync (
    .clk(clk), .arst(por_req),
    .d({rst_pin_in, oscfail_req, pfail_req}), .q(async_s)
  );

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) pd_hist <= '1;
    else         pd_hist <= {pd_hist[MASK_LEN-2:0], pd_w};
  end

  assign pin_req = !async_s[2] && !pd_w && !(|pd_hist);

  always_comb begin
    req            = '0;
    req[SRC_POR]   = por_s;
    req[SRC_PFAIL] = async_s[0];
    req[SRC_OSCF]  = async_s[1];
    req[SRC_PIN]   = pin_req;
    req[SRC_SW]    = sw_rst_cmd;
  end

  rstseq_fsm #(
    .HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .INIT_CYC(INIT_CYC)
  ) u_fsm (
    .clk(clk), .arst(por_req), .req_any(|req), .skip_settle(cause[SRC_SW]),
    .state(state), .osc_done(osc_done), .init_done(init_done)
  );

  rstseq_cause u_cause (
    .clk(clk), .arst(por_req), .req(req), .in_hold(in_hold), .cause(cause)
  );

  rstseq_irq u_irq (
    .clk(clk), .arst(por_req), .in_hold(in_hold),
    .set({init_done, osc_done}), .clr(irq_clr),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .flags(irq_flags), .irq(irq)
  );

  assign in_hold    = (state == ST_HOLD);
  assign hw_kind    = !cause[SRC_SW];
  assign pd_w       = in_hold && hw_kind;
  assign in_reset   = in_hold;
  assign reg_rst    = in_hold;
  assign bufptr_rst = in_hold;
  assign pad_hiz    = in_hold;
  assign osc_en     = !pd_w;
  assign rst_pin_pd = pd_w;
  assign rst_cause  = cause;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       por_req,
  input logic       in_reset,
  input logic       osc_en,
  input logic       rst_pin_pd,
  input logic       irq,
  input logic [1:0] irq_flags,
  input logic [4:0] rst_cause
);
  // R3
  pin_pd_only_in_reset_chk: assert property (@(posedge clk) disable iff (por_req)
    rst_pin_pd |-> in_reset);

  // R3
  osc_off_only_in_reset_chk: assert property (@(posedge clk) disable iff (por_req)
    !osc_en |-> in_reset);

  // R8
  cause_onehot_chk: assert property (@(posedge clk) disable iff (por_req)
    $countones(rst_cause) == 1);

  // R4
  sw_no_osc_flag_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(irq_flags[0]) |-> !rst_cause[4]);

  // R2
  hold_flags_clear_chk: assert property (@(posedge clk) disable iff (por_req)
    (in_reset && $past(in_reset)) |-> (irq_flags == 2'b00));

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (por_req)
    irq |-> (|irq_flags));

  // R6
  osc_flag_when_running_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(irq_flags[0]) |-> (osc_en && !in_reset));
endmodule

bind rstseq_ctrl rstseq_chk u_chk (
  .clk(clk), .por_req(por_req), .in_reset(in_reset), .osc_en(osc_en),
  .rst_pin_pd(rst_pin_pd), .irq(irq), .irq_flags(irq_flags), .rst_cause(rst_cause)
);

// File: tb/test_rstseq_ctrl.sv
`timescale 1ns/1ps
module test_rstseq_ctrl;
  localparam int H = 8;
  localparam int S = 12;
  localparam int I = 6;

  logic clk = 1'b0;
  logic por = 1'b1, pfail = 1'b0, oscf = 1'b0, pin_ext_low = 1'b0, sw = 1'b0;
  logic ien_we = 1'b0;
  logic [1:0] ien_wdata = 2'b00, irq_clr = 2'b00;
  logic in_reset, reg_rst, bufptr_rst, pad_hiz, osc_en, rst_pin_pd, irq;
  logic [1:0] irq_flags;
  logic [4:0] rst_cause;
  logic pin_line;

  int vec = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign pin_line = !(pin_ext_low || rst_pin_pd);

  rstseq_ctrl #(.HOLD_CYC(H), .SETTLE_CYC(S), .INIT_CYC(I)) i_rstseq_ctrl (
    .clk(clk), .por_req(por), .pfail_req(pfail), .oscfail_req(oscf),
    .rst_pin_in(pin_line), .sw_rst_cmd(sw), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .irq_clr(irq_clr), .in_reset(in_reset), .reg_rst(reg_rst), .bufptr_rst(bufptr_rst),
    .pad_hiz(pad_hiz), .osc_en(osc_en), .rst_pin_pd(rst_pin_pd), .irq(irq),
    .irq_flags(irq_flags), .rst_cause(rst_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected cause: lowest active bit of {sw,pin,oscf,pfail,por}
  function automatic logic [4:0] exp_cause(input logic [4:0] reqs);
    for (int i = 0; i < 5; i++) if (reqs[i]) return 5'(1) << i;
    return 5'b0;
  endfunction

  function automatic int exp_async_fall(input logic [2:0] which, input int k);
    if (which[0] || which[1]) return H + 2;
    return 3 + H - k;
  endfunction

  task automatic count_fall(output int n);
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (in_reset && n < 1000);
  endtask

  task automatic measure(input logic is_sw, input string tag);
    int n;
    logic stayed;
    stayed = 1'b1;
    if (!is_sw) begin
      n = 0;
      do begin
        @(posedge clk); n++; @(negedge clk);
        if (in_reset) stayed = 1'b0;
      end while (!irq_flags[0] && n < 1000);
      chk({"R6 settle ", tag}, n, S);
    end
    n = 0;
    do begin
      @(posedge clk); n++; @(negedge clk);
      if (in_reset) stayed = 1'b0;
    end while (!irq_flags[1] && n < 1000);
    chk({"R7 init ", tag}, n, I);
    chk({"R9 no retrigger ", tag}, stayed, 1'b1);
    if (is_sw) chk({"R4 no osc flag ", tag}, irq_flags[0], 1'b0);
  endtask

  // which: bit0 pfail, bit1 oscf, bit2 pin
  task automatic fire_async(input logic [2:0] which, input int k);
    int n;
    pfail = which[0]; oscf = which[1]; pin_ext_low = which[2];
    repeat (k) @(negedge clk);
    chk("R3 in reset", in_reset, 1'b1);
    chk("R3 osc stopped", osc_en, 1'b0);
    chk("R3 pin pulled", rst_pin_pd, 1'b1);
    chk("R2 pads/regs", {reg_rst, bufptr_rst, pad_hiz}, 3'b111);
    chk("R8 cause", rst_cause, exp_cause({1'b0, which[2], which[1], which[0], 1'b0}));
    pfail = 1'b0; oscf = 1'b0; pin_ext_low = 1'b0;
    count_fall(n);
    chk((which[1:0] != 0) ? "R5 hold release" : "R9 pin hold", n, exp_async_fall(which, k));
    measure(1'b0, "hw");
  endtask

  task automatic fire_sw();
    int n;
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    chk("R4 in reset", in_reset, 1'b1);
    chk("R4 osc kept", osc_en, 1'b1);
    chk("R4 pin free", rst_pin_pd, 1'b0);
    chk("R8 sw cause", rst_cause, 5'b10000);
    count_fall(n);
    chk("R5 sw hold", n + 1, H + 1);
    measure(1'b1, "sw");
  endtask

  task automatic fire_por(input int k);
    int n;
    por = 1'b1;
    repeat (k) @(negedge clk);
    chk("R1 por reset", {in_reset, rst_pin_pd, osc_en, irq, irq_flags}, 6'b110000);
    chk("R1 por cause", rst_cause, 5'b00001);
    por = 1'b0;
    count_fall(n);
    chk("R5 por hold", n, H + 2);
    measure(1'b0, "por");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", {in_reset, rst_pin_pd, osc_en, irq, irq_flags}, 6'b110000);
    chk("R1 reset cause", rst_cause, 5'b00001);
    chk("R2 reset requests", {reg_rst, bufptr_rst, pad_hiz}, 3'b111);
    por = 1'b0;
    count_fall(n);
    chk("R5 first release", n, H + 2);
    measure(1'b0, "boot");

    // R8 priority with simultaneous requests
    fire_async(3'b011, 5);
    fire_async(3'b110, 4);

    // R10 and R11 flags and enables
    chk("R11 irq both", irq, 1'b1);
    ien_we = 1'b1; ien_wdata = 2'b00;
    @(negedge clk); ien_we = 1'b0;
    chk("R11 masked", irq, 1'b0);
    ien_we = 1'b1; ien_wdata = 2'b10;
    @(negedge clk); ien_we = 1'b0;
    chk("R11 init only", irq, 1'b1);
    irq_clr = 2'b10;
    @(negedge clk); irq_clr = 2'b00;
    chk("R10 clear init", irq_flags, 2'b01);
    chk("R11 irq after clear", irq, 1'b0);
    irq_clr = 2'b01;
    @(negedge clk); irq_clr = 2'b00;
    chk("R10 clear osc", irq_flags, 2'b00);

    // R12 retrigger during settle window
    pfail = 1'b1;
    repeat (4) @(negedge clk);
    pfail = 1'b0;
    count_fall(n);
    repeat (3) @(negedge clk);
    oscf = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 back in reset", in_reset, 1'b1);
    chk("R12 no osc flag", irq_flags, 2'b00);
    chk("R12 cause", rst_cause, 5'b00100);
    oscf = 1'b0;
    count_fall(n);
    chk("R12 hold", n, H + 2);
    measure(1'b0, "r12");

    // R8 upgrade: supply drop during software hold
    sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    pfail = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 upgraded cause", rst_cause, 5'b00010);
    chk("R8 upgraded pulldown", {rst_pin_pd, osc_en}, 2'b10);
    pfail = 1'b0;
    count_fall(n);
    chk("R5 upgrade hold", n, H + 2);
    measure(1'b0, "upg");

    fire_sw();

    for (int it = 0; it < 24; it++) begin
      int r, k;
      logic [2:0] w;
      r = int'($urandom % 6);
      k = 4 + int'($urandom % 4);
      case (r)
        0: fire_async(3'b001, k);
        1: fire_async(3'b010, k);
        2: fire_async(3'b100, k);
        3: fire_sw();
        4: begin
          w = 3'b111 & ~(3'b001 << ($urandom % 3));
          fire_async(w, k);
        end
        default: fire_por(k);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule